// File: doc/BRIEF.md
# Adaptive DMA Request Holdoff Governor

This block decides when a bus-mastering agent may drive its DMA request line again after the host has taken away its acknowledge. Four request channels share the bus in a fixed priority order. When the acknowledge drops, the block holds its own request low for a while. The holdoff is short when nothing below the selected channel is competing. It is long when a lower-priority channel is waiting, so that a higher-priority master cannot starve a lower one.

The two holdoff times (1.1 µs and 2.6 µs) are turned into whole clock cycles from the clock frequency parameter. The count always rounds up, so the minimum time is never cut short. The other channels' request lines reach the block asynchronously and pass through a two-flop synchronizer. The long-or-short choice is made when the acknowledge falls. A lower request that appears while the short window is still running switches the window to long.

The ports carry no data stream. All pins are plain level controls, so no valid/ready handshake and no back-pressure apply.

Top module: `drq_holdoff_gov`

## Requirements
- R1: `chan_sel` picks the block's own channel: 0, 1, 2 and 3 stand for the channels of rank 0 (highest priority) to rank 3 (lowest). Bit i of `peer_drq` is the request of rank i. A rank is "lower" than the selected one when its index is larger.
- R2: If a lower-rank request is seen (after synchronization) in the cycle where `dack` falls, `drq` stays low for exactly LONG_CYC cycles, counting that cycle. LONG_CYC = ceil(2.6 µs × CLK_FREQ_HZ), which is 260 at 100 MHz.
- R3: If no request of any rank is present when `dack` falls and none appears during the window, `drq` stays low for exactly SHORT_CYC = ceil(1.1 µs × CLK_FREQ_HZ) cycles, which is 110 at 100 MHz.
- R4: Requests of higher rank than the selected channel do not lengthen the holdoff. With only such requests present, the holdoff is SHORT_CYC.
- R5: A lower-rank request that becomes visible while the short window is still running extends the holdoff to LONG_CYC, measured from the `dack` fall.
- R6: The `peer_drq` bit of the selected channel itself is ignored when choosing the holdoff length.
- R7: While `rst_n` is low, `drq` is low whatever `need_bus` is.
- R8: Outside a holdoff, `drq` equals `need_bus`, including while `dack` is high. During a holdoff, `drq` is low even when `need_bus` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chan_sel | input | 2 | Own channel rank, 0 = highest priority |
| dack | input | 1 | Acknowledge for the own channel, active high, synchronous to clk |
| peer_drq | input | 4 | Request lines of all four ranks, asynchronous |
| need_bus | input | 1 | Internal request for the bus |
| drq | output | 1 | DMA request for the own channel |

## Verification
On every cycle, the assertions check four things. `drq` is quiet in reset. It is low in the cycle where the acknowledge falls. It never rises without `need_bus`. Once a long window is chosen, it is not left before LONG_CYC. The exact length of each holdoff, the rank-mask decoding for every channel, the ignoring of the block's own bit and the switch from short to long in the middle of a window can only be shown by the bench's scenarios. These scenarios count cycles from the acknowledge fall to the rise of `drq`.

// File: rtl/drq_gov_pkg.sv
package drq_gov_pkg;
  localparam int unsigned NUM_RANKS = 4;

  // Whole cycles covering at least the given time, rounded up
  function automatic int unsigned ns_to_cycles(longint unsigned hz, longint unsigned ns);
    longint unsigned prod;
    prod = hz * ns;
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  // Ranks strictly lower in priority (larger index) than the selected one
  function automatic logic [NUM_RANKS-1:0] lower_mask(logic [1:0] sel);
    logic [NUM_RANKS-1:0] m;
    for (int i = 0; i < NUM_RANKS; i++) m[i] = (i > int'(sel));
    return m;
  endfunction
endpackage

// File: rtl/drq_sync2.sv
module drq_sync2 #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_in[g];
        stab_q <= meta_q;
      end
    end
    assign sync_out[g] = stab_q;
  end
endmodule

// File: rtl/drq_holdoff_timer.sv
module drq_holdoff_timer #(
  parameter int SHORT_CYC = 110,
  parameter int LONG_CYC  = 260
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic lower_req,
  output logic hold
);
  localparam int CW = $clog2(LONG_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          hold_q, long_q, long_eff;
  logic [CW-1:0] lim_m1;

  assign long_eff = long_q | lower_req;
  assign lim_m1   = long_eff ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      long_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      hold_q <= 1'b1;
      long_q <= lower_req;
      cnt_q  <= CW'(1);
    end else if (hold_q) begin
      long_q <= long_eff;
      if (cnt_q >= lim_m1) hold_q <= 1'b0;
      else cnt_q <= cnt_q + CW'(1);
    end
  end

  assign hold = hold_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> cnt_q < CW'(LONG_CYC)); // R2
  AST_SHORT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> $past(cnt_q) >= CW'(SHORT_CYC - 1)); // R3
  AST_LONG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !start && long_eff && cnt_q < CW'(LONG_CYC - 1)) |=> hold_q); // R5
endmodule

// File: rtl/drq_holdoff_gov.sv
module drq_holdoff_gov
  import drq_gov_pkg::*;
#(
  parameter longint unsigned CLK_FREQ_HZ = 100_000_000,
  parameter int unsigned     SHORT_NS    = 1100,
  parameter int unsigned     LONG_NS     = 2600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] chan_sel,
  input  logic       dack,
  input  logic [3:0] peer_drq,
  input  logic       need_bus,
  output logic       drq
);
  localparam int SHORT_CYC = int'(ns_to_cycles(CLK_FREQ_HZ, SHORT_NS));
  localparam int LONG_CYC  = int'(ns_to_cycles(CLK_FREQ_HZ, LONG_NS));

  logic [NUM_RANKS-1:0] peer_s;
  logic                 dack_q, fall, lower_req, hold;

  drq_sync2 #(.WIDTH(NUM_RANKS)) i_sync (
    .clk(clk), .rst_n(rst_n), .async_in(peer_drq), .sync_out(peer_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dack_q <= 1'b0;
    else        dack_q <= dack;
  end

  assign fall      = dack_q & ~dack;
  assign lower_req = |(peer_s & lower_mask(chan_sel));

  drq_holdoff_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) i_timer (
    .clk(clk), .rst_n(rst_n), .start(fall), .lower_req(lower_req), .hold(hold)
  );

  assign drq = rst_n & need_bus & ~hold & ~fall;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !drq); // R7
  AST_FALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (dack_q && !dack) |-> !drq); // R8
  AST_DRQ_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    drq |-> need_bus); // R8
endmodule

// File: tb/test_drq_holdoff_gov.sv
module test_drq_holdoff_gov;
  localparam int SHORT_EXP = 110; // ceil(1.1us * 100 MHz)
  localparam int LONG_EXP  = 260; // ceil(2.6us * 100 MHz)
  localparam int NV = 10;
  // {chan_sel[1:0], peer_drq[3:0], expect_long}
  localparam logic [6:0] VEC [NV] = '{
    {2'd0, 4'b0000, 1'b0},  // R3 idle bus
    {2'd0, 4'b0010, 1'b1},  // R2 rank1 below rank0
    {2'd0, 4'b1000, 1'b1},  // R2 rank3 below rank0
    {2'd1, 4'b0001, 1'b0},  // R4 only higher
    {2'd1, 4'b0100, 1'b1},  // R2 R1 lower for rank1
    {2'd2, 4'b0011, 1'b0},  // R4 two higher
    {2'd2, 4'b1000, 1'b1},  // R2 R1
    {2'd3, 4'b0111, 1'b0},  // R4 lowest rank never long
    {2'd1, 4'b0010, 1'b0},  // R6 own bit
    {2'd3, 4'b1000, 1'b0}   // R6 own bit, lowest
  };

  logic clk = 1'b0, rst_n = 1'b0, dack = 1'b0, need_bus = 1'b0;
  logic [1:0] chan_sel = '0;
  logic [3:0] peer_drq = '0;
  logic drq;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  drq_holdoff_gov i_drq_holdoff_gov (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .dack(dack),
    .peer_drq(peer_drq), .need_bus(need_bus), .drq(drq)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drop dack at a negedge; returns cycles until drq rises (mid-window peer injection optional)
  task automatic measure(input int inject_at, input logic [3:0] inject, output int k);
    dack = 1'b0;
    #1;
    check("R8 fall cycle", int'(drq), 0);
    k = 0;
    while (k < 400) begin
      @(negedge clk);
      k++;
      if (k == inject_at) peer_drq = inject;
      #1;
      if (drq) break;
    end
  endtask

  initial begin
    int k;
    need_bus = 1'b1;
    repeat (3) @(negedge clk);
    #1 check("R7 reset", int'(drq), 0);
    @(negedge clk) rst_n = 1'b1;
    #1 check("R8 idle", int'(drq), 1);
    need_bus = 1'b0;
    #1 check("R8 no need", int'(drq), 0);
    need_bus = 1'b1; dack = 1'b1;
    @(negedge clk); #1 check("R8 during dack", int'(drq), 1);

    for (int v = 0; v < NV; v++) begin
      chan_sel = VEC[v][6:5];
      peer_drq = VEC[v][4:1];
      dack = 1'b1;
      repeat (5) @(negedge clk);
      measure(-1, 4'b0, k);
      check(VEC[v][0] ? "R2 long" : "R3/R4/R6 short", k, VEC[v][0] ? LONG_EXP : SHORT_EXP);
      check("R1 drq after holdoff", int'(drq), 1);
    end

    // R5: lower request shows up during the short window
    chan_sel = 2'd0; peer_drq = 4'b0000; dack = 1'b1;
    repeat (5) @(negedge clk);
    measure(50, 4'b0100, k);
    check("R5 extend", k, LONG_EXP);

    // R8: need_bus high in the middle of a holdoff is blocked
    peer_drq = 4'b0000; dack = 1'b1;
    repeat (5) @(negedge clk);
    need_bus = 1'b0;
    dack = 1'b0;
    repeat (20) @(negedge clk);
    need_bus = 1'b1;
    #1 check("R8 blocked in holdoff", int'(drq), 0);

    // R7: reset in the middle of traffic
    rst_n = 1'b0;
    #1 check("R7 reset mid", int'(drq), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule